// File: doc/BRIEF.md
# SHA-512 Compression Round Engine

This block performs the compression step of SHA-512 for one 1024-bit message block. A start pulse loads a 512-bit chaining value into eight 64-bit working words. The engine then runs one round per clock for 80 clocks. During each round it presents the current round number on an index output. An external message-schedule unit and an external constant source both answer that index combinationally, with the message word and the round constant.

After the last round, each working word is added modulo 2^64 to the matching chaining word it was loaded from. The sum is registered onto the result port, and a one-cycle done pulse marks it. In the same clock the working words and the held copy of the chaining input are cleared to zero.

Padding, length encoding, multi-block sequencing, the message schedule and the constant table all live outside this block.

Top module: `sha512_round_engine`

## Requirements
- R1: The rotated sum for e is ror(e,14) XOR ror(e,18) XOR ror(e,41). The choose term is (e AND f) XOR (NOT e AND g). All operations are on 64-bit words.
- R2: The rotated sum for a is ror(a,28) XOR ror(a,34) XOR ror(a,39). The majority term is (a AND b) OR ((a OR b) AND c).
- R3: Each round computes t1 = h + sum(e) + choose + K + W modulo 2^64. The new a is sum(a) + majority + t1. The new e is d + t1. Every other word moves one role down: a→b, b→c, c→d, e→f, f→g, g→h.
- R4: A start sampled while idle makes busy high on the next clock with round_idx 0. round_idx then rises by one per clock, through 0..79 in order.
- R5: The clock after round 79, done is high for exactly one cycle and busy is low. chain_out then holds the sum modulo 2^64 of each final working word and the loaded chaining word. Word j (j=0 is a, up to j=7 is h) sits at bits [64j+63:64j] of chain_in and of chain_out. chain_out keeps its value until the next completion.
- R6: A start pulse or a change on chain_in while busy is ignored: the result is the one for the originally loaded value.
- R7: Once a block has completed, the working words and the held chaining copy are zero and round_idx reads 0 for as long as the engine is idle.
- R8: A synchronous reset clears busy, done, round_idx, chain_out and all working state, including in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a block; sampled only while idle |
| chain_in | input | 512 | Incoming chaining value, word j at [64j+63:64j] |
| k_in | input | 64 | Round constant for round_idx |
| w_in | input | 64 | Message word for round_idx |
| round_idx | output | 7 | Current round number, 0 when idle |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse with a valid result |
| chain_out | output | 512 | Updated chaining value |

## Verification
The bench runs many blocks with pseudo-random constants, message words and chaining values, plus all-zero and all-ones corners. Each result is compared with a conventional shifting-register model of the rounds, so any wrong rotation amount, Maj or Ch form, or role mapping corrupts most output words. It pokes start and chain_in mid-block; an engine that reloads would return the poked value's digest. It also checks the index sequence on every round and the single-cycle done. A reset in the middle of a block must leave the engine idle with a zero result; leftover state would show up as a wrong next digest.

// File: rtl/sha512_round_engine.sv
module sha512_round_engine #(
  parameter int ROUNDS = 80,
  parameter int IDXW   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [511:0]     chain_in,
  input  logic [63:0]      k_in,
  input  logic [63:0]      w_in,
  output logic [IDXW-1:0]  round_idx,
  output logic             busy,
  output logic             done,
  output logic [511:0]     chain_out
);
  localparam int ENDROT = ROUNDS % 8;

  logic [7:0][63:0] wr, nxt;
  logic [511:0]     base, fin;
  logic [IDXW-1:0]  rnd;
  logic             busy_q, done_q;
  logic [511:0]     res_q;
  logic [2:0]       slot [8];

  // role j lives in physical slot (j - round) mod 8
  for (genvar j = 0; j < 8; j++) begin : g_slot
    assign slot[j] = 3'(j) - rnd[2:0];
  end

  wire [63:0] a = wr[slot[0]];
  wire [63:0] b = wr[slot[1]];
  wire [63:0] c = wr[slot[2]];
  wire [63:0] d = wr[slot[3]];
  wire [63:0] e = wr[slot[4]];
  wire [63:0] f = wr[slot[5]];
  wire [63:0] g = wr[slot[6]];
  wire [63:0] h = wr[slot[7]];

  wire [63:0] big1 = {e[13:0], e[63:14]} ^ {e[17:0], e[63:18]} ^ {e[40:0], e[63:41]};
  wire [63:0] big0 = {a[27:0], a[63:28]} ^ {a[33:0], a[63:34]} ^ {a[38:0], a[63:39]};
  wire [63:0] chs  = (e & f) ^ (~e & g);
  wire [63:0] maj  = (a & b) | ((a | b) & c);
  wire [63:0] t1   = h + big1 + chs + k_in + w_in;

  always_comb begin
    nxt = wr;
    nxt[slot[3]] = d + t1;
    nxt[slot[7]] = big0 + maj + t1;
  end

  for (genvar j = 0; j < 8; j++) begin : g_fin
    localparam int S = (j - ENDROT + 8) % 8;
    assign fin[64*j +: 64] = nxt[S] + base[64*j +: 64];
  end

  wire last = busy_q && (rnd == IDXW'(ROUNDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr     <= '0;
      base   <= '0;
      rnd    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          wr     <= chain_in;
          base   <= chain_in;
          rnd    <= '0;
          busy_q <= 1'b1;
        end
      end else if (last) begin
        res_q  <= fin;
        done_q <= 1'b1;
        busy_q <= 1'b0;
        wr     <= '0;
        base   <= '0;
        rnd    <= '0;
      end else begin
        wr  <= nxt;
        rnd <= rnd + 1'b1;
      end
    end
  end

  assign round_idx = rnd;
  assign busy      = busy_q;
  assign done      = done_q;
  assign chain_out = res_q;
endmodule

// File: rtl/sha512_round_engine_chk.sv
module sha512_round_engine_chk #(
  parameter int ROUNDS = 80,
  parameter int IDXW   = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic [IDXW-1:0]     round_idx,
  input logic [511:0]        chain_out,
  input logic [7:0][63:0]    wr,
  input logic [511:0]        base
);
  p_idx_step_r4: assert property (@(posedge clk) disable iff (rst)
    busy && round_idx != IDXW'(ROUNDS - 1) |=> busy && round_idx == IDXW'($past(round_idx) + 1));

  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    !busy && start |=> busy && round_idx == '0);

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    busy && round_idx == IDXW'(ROUNDS - 1) |=> done && !busy);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_base_held_r6: assert property (@(posedge clk) disable iff (rst)
    busy && round_idx != IDXW'(ROUNDS - 1) |=> $stable(base));

  p_idle_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> wr == '0 && base == '0 && round_idx == '0);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> !busy && !done && chain_out == '0 && round_idx == '0);
endmodule

bind sha512_round_engine sha512_round_engine_chk #(.ROUNDS(ROUNDS), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .round_idx(round_idx), .chain_out(chain_out), .wr(wr), .base(base)
);

// File: tb/sha512_round_engine_bench.sv
module sha512_round_engine_bench;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [511:0] chain_in = '0;
  logic [63:0]  k_in, w_in;
  logic [6:0]   round_idx;
  logic         busy, done;
  logic [511:0] chain_out;

  logic [63:0]  seed = '0;
  bit           zk = 1'b0;
  int           total = 0;
  int           bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [63:0] mix(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x >> 29);
    y = y * 64'hBF58476D1CE4E5B9;
    y = y ^ (y >> 32);
    y = y * 64'h94D049BB133111EB;
    return y ^ (y >> 31);
  endfunction

  function automatic logic [63:0] kf(input logic [6:0] t, input logic [63:0] sd, input bit z);
    return z ? 64'd0 : mix({57'd0, t} * 64'h9E3779B97F4A7C15 + sd);
  endfunction

  function automatic logic [63:0] wf(input logic [6:0] t, input logic [63:0] sd, input bit z);
    return z ? 64'd0 : mix(({57'd0, t} + 64'd200) * 64'hD1B54A32D192ED03 ^ sd);
  endfunction

  assign k_in = kf(round_idx, seed, zk);
  assign w_in = wf(round_idx, seed, zk);

  sha512_round_engine u_sha512_round_engine (
    .clk(clk), .rst(rst), .start(start), .chain_in(chain_in),
    .k_in(k_in), .w_in(w_in), .round_idx(round_idx), .busy(busy),
    .done(done), .chain_out(chain_out)
  );

  function automatic logic [63:0] ror(input logic [63:0] x, input int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  // conventional shifting model of the rounds
  function automatic logic [511:0] ref_comp(input logic [511:0] ch, input logic [63:0] sd, input bit z);
    logic [63:0] v [8];
    logic [63:0] t1, t2;
    logic [511:0] r;
    for (int j = 0; j < 8; j++) v[j] = ch[64*j +: 64];
    for (int t = 0; t < 80; t++) begin
      t1 = v[7] + (ror(v[4],14) ^ ror(v[4],18) ^ ror(v[4],41))
         + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kf(7'(t), sd, z) + wf(7'(t), sd, z);
      t2 = (ror(v[0],28) ^ ror(v[0],34) ^ ror(v[0],39))
         + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int j = 0; j < 8; j++) r[64*j +: 64] = v[j] + ch[64*j +: 64];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_idle_zero(input string req);
    check(!busy && !done && round_idx == 7'd0 && chain_out == '0, req,
          {chain_out, busy, done, round_idx}, '0);
  endtask

  task automatic run_block(input logic [511:0] ch, input logic [63:0] sd, input bit z, input bit poke);
    logic [511:0] exp;
    seed = sd; zk = z;
    exp = ref_comp(ch, sd, z);
    @(negedge clk);
    chain_in = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0; chain_in = ~ch;
    for (int t = 0; t < 80; t++) begin
      check(busy && !done && round_idx == 7'(t), "R4 round index", {505'd0, round_idx}, 512'(t));
      if (poke && t == 40) begin
        start = 1'b1; chain_in = {8{mix(sd + 64'd7)}};
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(done && !busy, "R5 done after last round", {510'd0, done, busy}, 512'd2);
    for (int j = 0; j < 8; j++)
      check(chain_out[64*j +: 64] == exp[64*j +: 64],
            poke ? "R6 start ignored while busy" : "R1/R2/R3/R5 result word",
            512'(chain_out[64*j +: 64]), 512'(exp[64*j +: 64]));
    check(round_idx == 7'd0, "R7 idle index", 512'(round_idx), '0);
    @(negedge clk);
    check(!done && !busy && chain_out == exp, "R5 single done pulse, result held", chain_out, exp);
    check(round_idx == 7'd0, "R7 index stays zero while idle", 512'(round_idx), '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle_zero("R8 reset state");
    rst = 1'b0;
    @(negedge clk);
    check_idle_zero("R7 idle after reset");

    run_block('0, 64'd0, 1'b1, 1'b0);
    run_block({512{1'b1}}, 64'd0, 1'b1, 1'b0);
    run_block('0, 64'h1234, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) begin
      logic [511:0] ch;
      for (int j = 0; j < 8; j++) ch[64*j +: 64] = mix(64'(i * 8 + j) + 64'h55);
      run_block(ch, mix(64'(i) + 64'hABC), 1'b0, (i % 3) == 1);
    end

    // reset in the middle of a block
    seed = 64'h77; zk = 1'b0;
    @(negedge clk);
    chain_in = {8{64'hDEADBEEF0BADF00D}}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle_zero("R8 reset mid-block");
    repeat (3) @(negedge clk);
    check_idle_zero("R8 stays idle after reset");
    run_block({8{64'h0123456789ABCDEF}}, 64'h99, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule